// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block is the digital sequencer that runs the self-calibration of a pipelined data converter. A start request comes in on a pin that has no fixed phase relation to the converter clock. The block retimes that pin through a chain of flops and watches its rising edge. As soon as the retimed request goes high, the block pulls its ready flag low. While the flag is low the converter stops normal conversion and its analog inputs are not used.

The block then checks that the request stays high for a minimum number of clocks. A request that is too short is dropped and the ready flag comes back high. A request that is long enough starts a calibration interval of fixed length. During that interval a calibration-active level and a periodic step pulse drive a placeholder coefficient-update engine. When the interval ends, ready returns high. A new calibration needs a fresh low-to-high transition of the request. A request that arrives during an interval has no effect.

Top module: `selfcal_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ready` is 1 and `cal_active` and `cal_tick` are 0.
- R2: The request passes through SYNC_STAGES (default 2) flops. If the request is first sampled high at clock edge k, `ready` falls at edge k+2.
- R3: A request sampled high on only N consecutive edges, with N below MIN_PULSE (default 4), is rejected. `ready` returns high at edge k+2+N and `cal_active` never rises.
- R4: A request held high for at least MIN_PULSE edges is accepted. `ready` then stays low for exactly CAL_CYCLES (default 17400) clock cycles and rises at edge k+2+CAL_CYCLES.
- R5: For an accepted request, `cal_active` rises at edge k+5 and falls at the same edge where `ready` rises. `cal_active` is never high while `ready` is high.
- R6: `cal_tick` is a one-cycle pulse. It is high after edges k+5+m*TICK_DIV (m ≥ 1, default TICK_DIV 64) that fall no later than edge k+2+CAL_CYCLES. It never pulses outside an accepted interval.
- R7: A rising request seen while `ready` is low is ignored: the running interval neither restarts nor stretches. Only a low-to-high transition of the retimed request, seen while idle, starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, running continuously |
| rst | input | 1 | Synchronous active-high reset |
| cal_req_async | input | 1 | Start-calibration request, asynchronous to clk |
| ready | output | 1 | 1: normal conversion; 0: calibration pending or running |
| cal_active | output | 1 | High during an accepted calibration interval |
| cal_tick | output | 1 | Single-cycle step strobe for the coefficient-update engine |

## Verification
The properties assume the request line never stays high longer than one calibration interval. They also assume the request returns low between separate requests, so every start is a clean edge through the synchronizer. The stimulus changes the request only at falling clock edges. Every pulse lasts far less than CAL_CYCLES, and each pulse is followed by a low gap longer than the synchronizer depth. Pulses sent during a busy interval end well before that interval finishes, so their edges can never be mistaken for a new start.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_QUAL = 2'd1,
    ST_RUN  = 2'd2
  } cal_state_e;
endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/cal_fsm.sv
module cal_fsm
  import cal_pkg::*;
#(
  parameter int MIN_PULSE  = 4,
  parameter int CAL_CYCLES = 17400
) (
  input  logic clk,
  input  logic rst,
  input  logic req_lvl,
  input  logic req_rise,
  output logic ready,
  output logic active
);
  localparam int WW = $clog2(MIN_PULSE + 1);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam logic [WW-1:0] WIDTH_LAST = WW'(MIN_PULSE - 1);
  localparam logic [CW-1:0] SPAN_END   = CW'(CAL_CYCLES);

  cal_state_e    state, nxt;
  logic [WW-1:0] width_cnt;
  logic [CW-1:0] span_cnt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (req_rise) nxt = ST_QUAL;
      ST_QUAL: begin
        if (!req_lvl)                    nxt = ST_IDLE;
        else if (width_cnt == WIDTH_LAST) nxt = ST_RUN;
      end
      ST_RUN:  if (span_cnt == SPAN_END) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      width_cnt <= '0;
      span_cnt  <= '0;
      ready     <= 1'b1;
      active    <= 1'b0;
    end else begin
      state     <= nxt;
      width_cnt <= (state == ST_QUAL) ? width_cnt + 1'b1 : WW'(1);
      span_cnt  <= (nxt == ST_IDLE) ? '0 : span_cnt + 1'b1;
      ready     <= (nxt == ST_IDLE);
      active    <= (nxt == ST_RUN);
    end
  end

  // R3
  short_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_QUAL && !req_lvl) |=> ready);

  // R4
  span_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (span_cnt <= SPAN_END));

  // R7
  busy_ignores_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && req_rise && span_cnt != SPAN_END) |=> (state == ST_RUN));
endmodule

// File: rtl/cal_tick_gen.sv
module cal_tick_gen #(
  parameter int TICK_DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic tick
);
  localparam int TW = $clog2(TICK_DIV);
  localparam logic [TW-1:0] TC_LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] tc;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      tc   <= '0;
      tick <= 1'b0;
    end else if (tc == TC_LAST) begin
      tc   <= '0;
      tick <= 1'b1;
    end else begin
      tc   <= tc + 1'b1;
      tick <= 1'b0;
    end
  end

  // R6
  tick_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(active));

  // R6
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/selfcal_seq.sv
module selfcal_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 4,
  parameter int CAL_CYCLES  = 17400,
  parameter int TICK_DIV    = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic cal_req_async,
  output logic ready,
  output logic cal_active,
  output logic cal_tick
);
  logic req_lvl;
  logic req_rise;

  cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (cal_req_async),
    .lvl  (req_lvl),
    .rise (req_rise)
  );

  cal_fsm #(.MIN_PULSE(MIN_PULSE), .CAL_CYCLES(CAL_CYCLES)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_lvl  (req_lvl),
    .req_rise (req_rise),
    .ready    (ready),
    .active   (cal_active)
  );

  cal_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .active (cal_active),
    .tick   (cal_tick)
  );

  // R2
  ready_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(req_rise));

  // R5
  active_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    cal_active |-> !ready);
endmodule

// File: tb/selfcal_seq_test.sv
module selfcal_seq_test;
  localparam int CAL  = 17400;
  localparam int MINP = 4;
  localparam int DIV  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  wire  ready, act, tick;

  always #4 clk = ~clk;

  selfcal_seq uut (
    .clk           (clk),
    .rst           (rst),
    .cal_req_async (req),
    .ready         (ready),
    .cal_active    (act),
    .cal_tick      (tick)
  );

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  int ntick = 0;
  int nfull = 0;
  int cur_end = -100;
  int wr[$];
  int wl[$];
  int wf[$];
  bit done = 1'b0;

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic chk(input logic got, input logic exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s at edge %0d: got %0b expected %0b", tag, cyc, got, exp);
    end
  endtask

  // reference model: every request is a window of expected behaviour
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic er, ea, et;
      er = 1'b1; ea = 1'b0; et = 1'b0;
      foreach (wr[i]) begin
        if (cyc >= wr[i] + 2 && cyc < wr[i] + 2 + wl[i]) er = 1'b0;
        if (wf[i] != 0) begin
          if (cyc >= wr[i] + 5 && cyc < wr[i] + 2 + CAL) ea = 1'b1;
          if (cyc >= wr[i] + 5 + DIV && cyc <= wr[i] + 2 + CAL &&
              ((cyc - wr[i] - 5) % DIV) == 0) et = 1'b1;
        end
      end
      chk(ready, er, "R2 R3 R4 R7 ready");
      chk(act, ea, "R5 cal_active");
      chk(tick, et, "R6 cal_tick");
      if (tick === 1'b1) ntick++;
    end
  end

  task automatic send(input int n);
    int r;
    @(negedge clk);
    r = cyc + 1;
    if (r + 1 >= cur_end) begin
      wr.push_back(r);
      wl.push_back(n >= MINP ? CAL : n);
      wf.push_back(n >= MINP ? 1 : 0);
      if (n >= MINP) nfull++;
      cur_end = r + 2 + (n >= MINP ? CAL : n);
    end
    req = 1'b1;
    repeat (n) @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired at edge %0d", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready, 1'b1, "R1 ready in reset");
    chk(act, 1'b0, "R1 cal_active in reset");
    chk(tick, 1'b0, "R1 cal_tick in reset");
    rst = 1'b0;
    repeat (10) @(negedge clk);
    send(1);            // R3 shortest pulse rejected
    repeat (20) @(negedge clk);
    send(3);            // R3 one clock short of the minimum
    repeat (20) @(negedge clk);
    send(4);            // R4 minimum accepted width
    repeat (200) @(negedge clk);
    send(6);            // R7 request during a running interval
    repeat (CAL) @(negedge clk);
    send(10);           // R4 longer accepted pulse
    repeat (CAL + 40) @(negedge clk);
    send(2);            // R3 short pulse after a full interval
    repeat (30) @(negedge clk);
    // R6 total number of step strobes
    chk(ntick == nfull * ((CAL - 3) / DIV), 1'b1, "R6 tick total");
    finish_run();
  end
endmodule